// File: doc/BRIEF.md
# Streaming Block Cipher Mode Wrapper

This block sits between a 128-bit data stream and an external block cipher engine and applies one chaining mode to every block that passes through. The mode is chosen when the design is built: electronic codebook, cipher block chaining, cipher feedback (full 128-bit segment), output feedback, or counter. The wrapper keeps the chaining register, which holds the IV or the counter block. For each block it decides what the engine is asked to transform and in which direction. It then combines the engine's answer with the block to form the result.

Blocks arrive on a valid/ready input and leave on a valid/ready output, and either side may pause for as long as it likes. The engine is reached through a request port with valid/ready and a response port that answers after any number of cycles. A per-block decrypt flag is taken when the block is accepted. A load strobe presets the chaining register between blocks. Key handling and the cipher rounds belong to the engine and are not part of this block.

Top module: `bcm_stream_mode`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, eng_req_valid is 0, and the chaining register is all zeros.
- R2: Codebook mode (MODE = BCM_ECB): the output is E(block) when in_decrypt was 0 and D(block) when it was 1. The chaining register plays no part.
- R3: Block chaining mode (BCM_CBC): encrypt gives C = E(P xor V) and then V = C. Decrypt gives P = D(C) xor V and then V = C, and V changes only when that plaintext is accepted at the output.
- R4: Cipher feedback mode (BCM_CFB): the output is block xor E(V). After the output is accepted, V takes the ciphertext: the output when encrypting, the input block when decrypting.
- R5: Output feedback mode (BCM_OFB): the output is block xor E(V), and V takes E(V) after the output is accepted.
- R6: Counter mode (BCM_CTR): the output is block xor E(V). After each accepted output, bits [31:0] of V increase by one modulo 2^32 and bits [127:32] are unchanged.
- R7: eng_req_inverse is 0 on every request in BCM_CFB, BCM_OFB and BCM_CTR. In BCM_ECB and BCM_CBC it equals the block's decrypt flag.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_block does not change. No result is dropped.
- R9: Only one block is in flight at a time. in_ready is 0 from the cycle after an input handshake until the result is accepted, and idle cycles on in_valid do not alter any result.
- R10: iv_load with iv_value sets the chaining register only while the block is idle (in_ready = 1). A strobe while a block is in flight has no effect.
- R11: The decrypt flag is sampled at the input handshake. Later changes to in_decrypt do not affect that block, and an encrypt block and a decrypt block take the same number of cycles.
- R12: While eng_req_valid is 1 and eng_req_ready is 0, eng_req_valid stays 1 and eng_req_block does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Wrapper can take a block |
| in_block | input | 128 | Input data block |
| in_decrypt | input | 1 | 1 = decrypt this block, 0 = encrypt |
| out_valid | output | 1 | Result block offered |
| out_ready | input | 1 | Sink takes the result |
| out_block | output | 128 | Result data block |
| iv_load | input | 1 | Preset strobe for the chaining register |
| iv_value | input | 128 | IV or initial counter block |
| eng_req_valid | output | 1 | Request to the cipher engine |
| eng_req_ready | input | 1 | Engine takes the request |
| eng_req_block | output | 128 | Block for the engine to transform |
| eng_req_inverse | output | 1 | 1 = engine runs the inverse cipher |
| eng_rsp_valid | input | 1 | Engine result present, one pulse per request |
| eng_rsp_block | input | 128 | Engine result |

## Verification
The bench builds five copies of the wrapper side by side, one for each MODE value, all with a 128-bit block and a 32-bit counter field. This gives every chaining equation, the direction rule toward the engine, and both feedback paths (ciphertext and keystream) a run in the same test. Each copy talks to a reversible stand-in engine that stalls its request port and answers at random delays. The copies then encrypt and decrypt the same blocks and compare each round trip against the original plaintext. A counter preset just below 2^32 brings the low-field wraparound within reach in a few blocks.

// File: rtl/bcm_pkg.sv
// Shared types for the streaming block cipher mode wrapper.
// Assumes the enum order below is the MODE parameter encoding.
package bcm_pkg;

    typedef enum logic [2:0] {
        BCM_ECB = 3'd0,
        BCM_CBC = 3'd1,
        BCM_CFB = 3'd2,
        BCM_OFB = 3'd3,
        BCM_CTR = 3'd4
    } bcm_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_OUT  = 2'd3
    } bcm_state_e;

    // True for modes whose engine pass is always the forward cipher.
    function automatic logic fwd_only(input bcm_mode_e m);
        return (m == BCM_CFB) || (m == BCM_OFB) || (m == BCM_CTR);
    endfunction

endpackage

// File: rtl/bcm_ctrl.sv
// Block sequencer: takes one block, issues one engine request, waits for
// the response, then offers the result until the sink takes it.
// Assumes the engine returns exactly one response pulse per accepted request.
module bcm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic accept,
    output logic eng_req_valid,
    input  logic eng_req_ready,
    input  logic eng_rsp_valid,
    output logic capture,
    output logic out_valid,
    input  logic out_ready,
    output logic commit,
    output logic idle
);
    import bcm_pkg::*;

    bcm_state_e state_q;

    // Handshake strobes decoded from the current state.
    always_comb begin
        idle          = (state_q == ST_IDLE);
        in_ready      = idle;
        accept        = in_valid && idle;
        eng_req_valid = (state_q == ST_REQ);
        capture       = (state_q == ST_WAIT) && eng_rsp_valid;
        out_valid     = (state_q == ST_OUT);
        commit        = out_valid && out_ready;
    end

    // State register: advance on each handshake of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (in_valid)      state_q <= ST_REQ;
                ST_REQ:  if (eng_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (eng_rsp_valid) state_q <= ST_OUT;
                ST_OUT:  if (out_ready)     state_q <= ST_IDLE;
                default:                    state_q <= ST_IDLE;
            endcase
        end
    end

    // R8: an offered result is not withdrawn before it is taken.
    p_out_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid);

    // R12: an engine request is not withdrawn before it is taken.
    p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_valid && !eng_req_ready |=> eng_req_valid);

    // R9: after taking a block the input closes until the result leaves.
    p_single_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

endmodule

// File: rtl/bcm_chain.sv
// Chaining register (IV, feedback value or counter block).
// Assumes load is honoured only while the sequencer is idle; commit
// happens only when a result is taken, so the two never coincide.
module bcm_chain #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         idle,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         commit,
    input  logic [W-1:0] next_val,
    output logic [W-1:0] chain
);

    // Chaining state: preset when idle, advanced when a result is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (idle && load) begin
            chain <= load_val;
        end else if (commit) begin
            chain <= next_val;
        end
    end

    // R10: a preset strobe during a block leaves the register alone.
    p_load_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load && !idle && !commit |=> $stable(chain));

endmodule

// File: rtl/bcm_datapath.sv
// Mode datapath: chooses the engine input and direction, forms the result
// from the engine answer, and computes the next chaining value.
// Assumes data, flag and response are held in registers for the whole block.
module bcm_datapath #(
    parameter bcm_pkg::bcm_mode_e MODE  = bcm_pkg::BCM_CBC,
    parameter int                 W     = 128,
    parameter int                 CTR_W = 32
) (
    input  logic [W-1:0] data_q,
    input  logic         dec_q,
    input  logic [W-1:0] chain,
    input  logic [W-1:0] rsp_q,
    output logic [W-1:0] eng_block,
    output logic         eng_inverse,
    output logic [W-1:0] out_block,
    output logic [W-1:0] chain_next
);
    import bcm_pkg::*;

    localparam int HI_W = W - CTR_W;

    logic [CTR_W-1:0] ctr_low_inc;
    logic [W-1:0]     keystream_out;

    // Counter step on the low field, wrapping at its width.
    always_comb begin
        ctr_low_inc   = chain[CTR_W-1:0] + CTR_W'(1);
        keystream_out = data_q ^ rsp_q;
    end

    // Per-mode selection of engine input, result and feedback.
    always_comb begin
        eng_block   = data_q;
        eng_inverse = 1'b0;
        out_block   = rsp_q;
        chain_next  = chain;
        case (MODE)
            BCM_ECB: begin
                eng_inverse = dec_q;
            end
            BCM_CBC: begin
                eng_inverse = dec_q;
                if (dec_q) begin
                    out_block  = rsp_q ^ chain;
                    chain_next = data_q;
                end else begin
                    eng_block  = data_q ^ chain;
                    chain_next = rsp_q;
                end
            end
            BCM_CFB: begin
                eng_block  = chain;
                out_block  = keystream_out;
                chain_next = dec_q ? data_q : keystream_out;
            end
            BCM_OFB: begin
                eng_block  = chain;
                out_block  = keystream_out;
                chain_next = rsp_q;
            end
            BCM_CTR: begin
                eng_block  = chain;
                out_block  = keystream_out;
                chain_next = {chain[W-1:W-HI_W], ctr_low_inc};
            end
            default: begin
                eng_block = data_q;
            end
        endcase
    end

endmodule

// File: rtl/bcm_stream_mode.sv
// Top of the streaming block cipher mode wrapper. Holds the captured block,
// its direction flag and the engine response, and ties the sequencer,
// chaining register and mode datapath together.
// Assumes an external engine with a valid/ready request and a pulsed response.
module bcm_stream_mode #(
    parameter bcm_pkg::bcm_mode_e MODE  = bcm_pkg::BCM_CBC,
    parameter int                 BLK_W = 128,
    parameter int                 CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [BLK_W-1:0] in_block,
    input  logic             in_decrypt,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BLK_W-1:0] out_block,
    input  logic             iv_load,
    input  logic [BLK_W-1:0] iv_value,
    output logic             eng_req_valid,
    input  logic             eng_req_ready,
    output logic [BLK_W-1:0] eng_req_block,
    output logic             eng_req_inverse,
    input  logic             eng_rsp_valid,
    input  logic [BLK_W-1:0] eng_rsp_block
);
    import bcm_pkg::*;

    logic             accept;
    logic             capture;
    logic             commit;
    logic             idle;
    logic [BLK_W-1:0] data_q;
    logic             dec_q;
    logic [BLK_W-1:0] rsp_q;
    logic [BLK_W-1:0] chain;
    logic [BLK_W-1:0] chain_next;

    bcm_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .accept        (accept),
        .eng_req_valid (eng_req_valid),
        .eng_req_ready (eng_req_ready),
        .eng_rsp_valid (eng_rsp_valid),
        .capture       (capture),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .commit        (commit),
        .idle          (idle)
    );

    bcm_chain #(.W(BLK_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (idle),
        .load     (iv_load),
        .load_val (iv_value),
        .commit   (commit),
        .next_val (chain_next),
        .chain    (chain)
    );

    bcm_datapath #(.MODE(MODE), .W(BLK_W), .CTR_W(CTR_W)) u_dp (
        .data_q      (data_q),
        .dec_q       (dec_q),
        .chain       (chain),
        .rsp_q       (rsp_q),
        .eng_block   (eng_req_block),
        .eng_inverse (eng_req_inverse),
        .out_block   (out_block),
        .chain_next  (chain_next)
    );

    // Block and direction capture at the input handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dec_q  <= 1'b0;
        end else if (accept) begin
            data_q <= in_block;
            dec_q  <= in_decrypt;
        end
    end

    // Engine answer capture on its response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else if (capture) begin
            rsp_q <= eng_rsp_block;
        end
    end

    // R8: the offered result does not change while the sink stalls.
    p_out_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_block));

    // R12: the engine request block does not change while the engine stalls.
    p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_valid && !eng_req_ready |=> $stable(eng_req_block));

    generate
        if (fwd_only(MODE)) begin : g_fwd
            // R7: feedback and counter modes only run the forward cipher.
            p_fwd_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
                eng_req_valid |-> !eng_req_inverse);
        end else begin : g_dir
            // R7: codebook and block chaining follow the captured flag.
            p_dir_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
                accept |=> (eng_req_inverse == $past(in_decrypt)));
        end

        if (MODE == BCM_CTR) begin : g_ctr
            // R6: each taken result steps the low counter field by one.
            p_ctr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
                commit |=> (chain[CTR_W-1:0] == $past(chain[CTR_W-1:0]) + CTR_W'(1))
                           && (chain[BLK_W-1:CTR_W] == $past(chain[BLK_W-1:CTR_W])));
        end

        if (MODE == BCM_CBC) begin : g_cbc
            // R3: feedback waits for the sink to take the result.
            p_cbc_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && !out_ready |=> $stable(chain));
        end
    endgenerate

endmodule

// File: tb/tb_bcm_stream_mode.sv
`timescale 1ns/1ps
// Directed bench: five wrapper copies, one per mode, each with a stand-in
// reversible engine and its own scenario tasks.
module tb_bcm_stream_mode;

    localparam logic [127:0] KEY = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    logic [4:0] done;
    bit   reported = 0;

    always #4 clk = ~clk;

    function automatic logic [127:0] toy_enc(input logic [127:0] x);
        return {x[114:0], x[127:115]} ^ KEY;
    endfunction

    function automatic logic [127:0] toy_dec(input logic [127:0] y);
        logic [127:0] t;
        t = y ^ KEY;
        return {t[12:0], t[127:13]};
    endfunction

    // Reference from the mode equations: returns {result, next chain}.
    function automatic logic [255:0] ref_step(input int md, input bit dec,
                                              input logic [127:0] d,
                                              input logic [127:0] v);
        logic [127:0] o;
        logic [127:0] n;
        n = v;
        case (md)
            0: o = dec ? toy_dec(d) : toy_enc(d);
            1: if (dec) begin o = toy_dec(d) ^ v; n = d; end
               else begin o = toy_enc(d ^ v); n = o; end
            2: begin o = d ^ toy_enc(v); n = dec ? d : o; end
            3: begin o = d ^ toy_enc(v); n = toy_enc(v); end
            default: begin o = d ^ toy_enc(v); n = {v[127:32], v[31:0] + 32'd1}; end
        endcase
        return {o, n};
    endfunction

    function automatic string mode_tag(input int md);
        case (md)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
    endtask

    for (genvar m = 0; m < 5; m++) begin : g_mode
        localparam bcm_pkg::bcm_mode_e MD = bcm_pkg::bcm_mode_e'(m);

        logic         in_valid = 0, in_ready, in_decrypt = 0;
        logic [127:0] in_block = '0;
        logic         out_valid, out_ready = 0;
        logic [127:0] out_block;
        logic         iv_load = 0;
        logic [127:0] iv_value = '0;
        logic         eng_req_valid, eng_req_inverse;
        logic         eng_req_ready;
        logic [127:0] eng_req_block;
        logic         eng_rsp_valid;
        logic [127:0] eng_rsp_block;
        logic         fin = 0;

        logic [127:0] chain_m = '0;
        logic [127:0] last_out;
        bit           cur_dec = 0;
        int           lat_cfg = 0;

        assign done[m] = fin;

        bcm_stream_mode #(.MODE(MD)) dut (
            .clk(clk), .rst_n(rst_n),
            .in_valid(in_valid), .in_ready(in_ready), .in_block(in_block),
            .in_decrypt(in_decrypt),
            .out_valid(out_valid), .out_ready(out_ready), .out_block(out_block),
            .iv_load(iv_load), .iv_value(iv_value),
            .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
            .eng_req_block(eng_req_block), .eng_req_inverse(eng_req_inverse),
            .eng_rsp_valid(eng_rsp_valid), .eng_rsp_block(eng_rsp_block)
        );

        // Stand-in engine: random request stalls, random response delay.
        logic [15:0]  lfsr;
        logic         busy;
        int           cnt;
        logic [127:0] held;
        logic         pend;
        logic [127:0] pend_blk;
        always @(posedge clk) begin
            if (!rst_n) begin
                lfsr <= 16'hACE1 + 16'(m * 977);
                busy <= 0; cnt <= 0; pend <= 0;
                eng_req_ready <= 0; eng_rsp_valid <= 0; eng_rsp_block <= '0;
            end else begin
                lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                eng_rsp_valid <= 0;
                eng_req_ready <= (lat_cfg != 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
                if (pend)
                    check("R12 request held", eng_req_valid ? eng_req_block : ~pend_blk, pend_blk);
                pend     <= eng_req_valid && !eng_req_ready;
                pend_blk <= eng_req_block;
                if (eng_req_valid && eng_req_ready && !busy) begin
                    check("R7 engine direction", {127'b0, eng_req_inverse},
                          {127'b0, (m >= 2) ? 1'b0 : cur_dec});
                    busy <= 1;
                    cnt  <= (lat_cfg != 0) ? lat_cfg : int'(lfsr[5:4]);
                    held <= eng_req_inverse ? toy_dec(eng_req_block) : toy_enc(eng_req_block);
                end else if (busy) begin
                    if (cnt == 0) begin
                        eng_rsp_valid <= 1; eng_rsp_block <= held; busy <= 0;
                    end else begin
                        cnt <= cnt - 1;
                    end
                end
            end
        end

        task automatic load_iv(input logic [127:0] v);
            @(negedge clk); iv_load = 1; iv_value = v;
            @(negedge clk); iv_load = 0; iv_value = ~v;
            chain_m = v;
        endtask

        // One block through: optional gap, sink stall, flag flip, preset poke.
        task automatic send(input logic [127:0] d, input bit dec, input int gap,
                            input int stall, input string req, input bit flip,
                            input bit poke, output int cyc);
            logic [255:0] r;
            logic [127:0] first;
            repeat (gap) @(negedge clk);
            in_block = d; in_decrypt = dec; in_valid = 1; cur_dec = dec;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 0; in_block = ~d;
            if (flip) in_decrypt = ~dec;
            cyc = 0;
            if (poke) begin
                iv_load = 1; iv_value = 128'hDEAD_BEEF_0BAD_F00D_1234_5678_9ABC_DEF0;
                @(negedge clk); iv_load = 0; cyc++;
            end
            while (!out_valid) begin @(negedge clk); cyc++; end
            check("R9 input closed while busy", {127'b0, in_ready}, 128'd0);
            r = ref_step(m, dec, d, chain_m);
            first = out_block;
            repeat (stall) begin
                @(negedge clk);
                check("R8 result held", out_valid ? out_block : ~first, first);
            end
            check(req, out_block, r[255:128]);
            last_out = out_block;
            out_ready = 1;
            @(negedge clk);
            out_ready = 0;
            chain_m = r[127:0];
        endtask

        initial begin : scen
            logic [127:0] pt [3];
            logic [127:0] ct [3];
            int c1, c2, cx;
            pt[0] = 128'h6bc1bee22e409f96e93d7e117393172a;
            pt[1] = 128'hae2d8a571e03ac9c9eb76fac45af8e51;
            pt[2] = 128'h30c81c46a35ce411e5fbc1191a0a52ef;
            @(posedge rst_n);
            @(negedge clk);
            check("R1 in_ready", {127'b0, in_ready}, 128'd1);
            check("R1 out_valid", {127'b0, out_valid}, 128'd0);
            check("R1 eng_req_valid", {127'b0, eng_req_valid}, 128'd0);
            send(pt[0], 0, 0, 0, {"R1 zero chain ", mode_tag(m)}, 0, 0, cx);
            load_iv(128'h000102030405060708090a0b0c0d0e0f);
            for (int i = 0; i < 3; i++) begin
                send(pt[i], 0, i * 3, i * 2, {mode_tag(m), " encrypt"}, 0, 0, cx);
                ct[i] = last_out;
            end
            load_iv(128'h000102030405060708090a0b0c0d0e0f);
            for (int i = 0; i < 3; i++) begin
                send(ct[i], 1, 1, 1, {mode_tag(m), " decrypt"}, 0, 0, cx);
                check({mode_tag(m), " round trip"}, last_out, pt[i]);
            end
            send(pt[1], 0, 2, 3, "R10 preset ignored in flight", 0, 1, cx);
            lat_cfg = 2;
            send(pt[2], 0, 0, 0, "R11 flag sampled at accept", 1, 0, c1);
            send(pt[0], 1, 0, 0, "R11 decrypt block", 0, 0, c2);
            check("R11 equal cycles", 128'(c1), 128'(c2));
            lat_cfg = 0;
            load_iv(128'hf0f1f2f3f4f5f6f7f8f9fafbfffffffe);
            for (int i = 0; i < 3; i++)
                send(pt[i], 0, 0, 1, {mode_tag(m), " wrap"}, 0, 0, cx);
            fin = 1;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        wait (done == 5'h1f);
        repeat (2) @(negedge clk);
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!reported) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

endmodule